// File: doc/BRIEF.md
# Presence-detect EEPROM slave

A synthesizable model of the small serial memory that sits beside a memory module and describes it to the host over a two-wire bus. The block runs from a fast system clock. It samples the bus clock and data lines through a synchroniser, finds start and stop conditions, and answers a 7-bit device address. The low three bits of that address come from board strap inputs. The block pulls the data line low through an open-drain enable and never drives it high.

The 256-byte space is split in two. The lower half holds fixed module-description data, which includes a checksum byte worked out from the preset bytes. The upper half is free for the host to write. A host sets the byte pointer by writing it as the first data byte. It then writes further bytes, reads from the current pointer, or does a random read: a pointer-only write, a repeated start, and then a read. The pointer advances after every byte. Each completed write opens a busy window whose length is set by a parameter. During that window the block ignores the bus.

Top module: `pd_spd_slave`

## Requirements
- R1: The block acknowledges a received address byte only when its upper seven bits equal 1010 followed by `strap_sel[2:0]`. It drives SDA low during the ninth SCL clock to do so. Any other address gets no acknowledge, and the block stays silent until the next start.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. The block changes its own SDA drive only while SCL is low.
- R3: In a write, the first byte after the address loads the byte pointer. The block acknowledges the address, the pointer byte and every data byte that follows.
- R4: A data byte written while the pointer is 128 to 255 is stored. A data byte written while the pointer is 0 to 127 is acknowledged and leaves the stored contents unchanged.
- R5: A read with the direction bit (address bit 0) set to 1 returns data starting at the current pointer. The pointer advances by one after every byte, whether written or sent, and wraps from 255 to 0.
- R6: A random read returns the byte at the chosen pointer. It takes a write of the pointer only, a repeated start, and then a read address.
- R7: During a read the block sends the next byte when the master acknowledges. When the master does not acknowledge, the block releases SDA and sends nothing more until a start or a stop.
- R8: With no start seen since the last stop or reset, clocked bus traffic draws no response.
- R9: A stop that ends a transaction in which at least one data byte was received starts a busy window of `WR_BUSY_CLKS` clocks. During the window the block neither drives SDA nor acknowledges its address. A transaction that carried only a pointer starts no window.
- R10: The fixed contents are these. Bytes 0 to 4 are 0x80, 0x08, 0x04, 0x0B and 0x08. Bytes 5 to 62 each equal their index XOR 0x5A. Byte 63 is the low 8 bits of the sum of bytes 0 to 62. Bytes 64 to 127 are 0xFF. Bytes 128 to 255 read 0x00 after reset.
- R11: After reset the block does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| strap_sel | input | 3 | Board straps giving the low three address bits |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench keeps the default 256-byte space, so a single sequential read of 257 bytes covers every preset byte, the checksum, the reset state of the writable half and the pointer wrap. It sets `WR_BUSY_CLKS` to 300 in place of a real write-cycle time. This brings the busy window and its end into a short run, so an address probe inside the window and another after it both fit. The straps are fixed at 101, which leaves other addresses in the same family free for mismatch tests.

// File: rtl/pd_spd_pkg.sv
package pd_spd_pkg;

  localparam int BYTE_W = 8;
  localparam int CSUM_IDX = 63;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVADDR,
    PH_POINTER,
    PH_WDATA,
    PH_SLVACK,
    PH_SEND,
    PH_MSTACK,
    PH_HOLD
  } phase_t;

  // Fixed description bytes, except the checksum slot
  function automatic logic [7:0] fixed_byte(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      0: v = 8'h80;
      1: v = 8'h08;
      2: v = 8'h04;
      3: v = 8'h0B;
      4: v = 8'h08;
      default: v = (idx < CSUM_IDX) ? (8'(idx) ^ 8'h5A) : 8'hFF;
    endcase
    return v;
  endfunction

  // Modulo-256 sum of every fixed byte below the checksum slot
  function automatic logic [7:0] fixed_sum();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < CSUM_IDX; i++) s = s + fixed_byte(i);
    return s;
  endfunction

  localparam logic [7:0] PRESET_CSUM = fixed_sum();

  function automatic logic [7:0] preset_byte(input int unsigned idx);
    return (idx == CSUM_IDX) ? PRESET_CSUM : fixed_byte(idx);
  endfunction

  function automatic logic dev_match(input logic [6:0] rx, input logic [3:0] family,
                                     input logic [2:0] strap);
    return rx == {family, strap};
  endfunction

endpackage

// File: rtl/pd_bus_sampler.sv
module pd_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= (scl_pipe << 1) | SYNC_STAGES'(scl_i);
      sda_pipe <= (sda_pipe << 1) | SYNC_STAGES'(sda_i);
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl  = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  // data edges qualified by SCL held high across both samples
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/pd_write_timer.sv
module pd_write_timer #(
  parameter int unsigned BUSY_CLKS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CLKS + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (launch)        left_q <= CW'(BUSY_CLKS);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  generate
    if (BUSY_CLKS > 0) begin : g_chk
      assert_launch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy)
        else $error("write window did not open after a write stop");
    end
  endgenerate

endmodule

// File: rtl/pd_spd_store.sv
module pd_spd_store
  import pd_spd_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int PTR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HALF = MEM_BYTES / 2;

  logic [BYTE_W-1:0] user_q [HALF];
  logic              wr_user;

  // only the upper half accepts data
  assign wr_user = wr_en & wr_addr[PTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF; i++) user_q[i] <= '0;
    end else if (wr_user) begin
      user_q[wr_addr[PTR_W-2:0]] <= wr_data;
    end
  end

  assign rd_data = rd_addr[PTR_W-1] ? user_q[rd_addr[PTR_W-2:0]]
                                    : preset_byte(int'(rd_addr));

endmodule

// File: rtl/pd_link_fsm.sv
module pd_link_fsm
  import pd_spd_pkg::*;
#(
  parameter logic [3:0] DEV_FAMILY = 4'b1010,
  parameter int         PTR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        strap,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              launch,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_t            ph_q, after_ack_q;
  logic [CNT_W-1:0]  bit_q;
  logic              full_q;     // eighth bit taken, or master ack bit taken
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              wrote_q, mack_q;
  logic              byte_end;

  assign byte_end = scl_fall & full_q;
  assign wr_en    = (ph_q == PH_WDATA) & byte_end;
  assign wr_addr  = ptr_q;
  assign wr_data  = rx_q;
  assign rd_addr  = ptr_q;
  assign launch   = stop_ev & wrote_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      after_ack_q <= PH_IDLE;
      bit_q       <= '0;
      full_q      <= 1'b0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      wrote_q     <= 1'b0;
      mack_q      <= 1'b0;
      sda_oe      <= 1'b0;
    end else if (stop_ev) begin
      ph_q    <= PH_IDLE;
      full_q  <= 1'b0;
      wrote_q <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      ph_q   <= busy ? PH_IDLE : PH_DEVADDR;
      bit_q  <= '0;
      full_q <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (ph_q)
        PH_DEVADDR, PH_POINTER, PH_WDATA: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl};
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) full_q <= 1'b1;
          end else if (byte_end) begin
            full_q <= 1'b0;
            bit_q  <= '0;
            if (ph_q == PH_DEVADDR) begin
              if (dev_match(rx_q[BYTE_W-1:1], DEV_FAMILY, strap)) begin
                sda_oe      <= 1'b1;
                ph_q        <= PH_SLVACK;
                after_ack_q <= rx_q[0] ? PH_SEND : PH_POINTER;
              end else begin
                ph_q <= PH_IDLE;
              end
            end else if (ph_q == PH_POINTER) begin
              ptr_q       <= rx_q[PTR_W-1:0];
              sda_oe      <= 1'b1;
              ph_q        <= PH_SLVACK;
              after_ack_q <= PH_WDATA;
            end else begin
              ptr_q       <= ptr_q + 1'b1;
              wrote_q     <= 1'b1;
              sda_oe      <= 1'b1;
              ph_q        <= PH_SLVACK;
              after_ack_q <= PH_WDATA;
            end
          end
        end
        PH_SLVACK: begin
          if (scl_fall) begin
            if (after_ack_q == PH_SEND) begin
              tx_q   <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr_q  <= ptr_q + 1'b1;
            end else begin
              sda_oe <= 1'b0;
            end
            ph_q <= after_ack_q;
          end
        end
        PH_SEND: begin
          if (scl_rise) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) full_q <= 1'b1;
          end else if (byte_end) begin
            full_q <= 1'b0;
            bit_q  <= '0;
            sda_oe <= 1'b0;
            ph_q   <= PH_MSTACK;
          end else if (scl_fall) begin
            tx_q   <= tx_q << 1;
            sda_oe <= ~tx_q[BYTE_W-2];
          end
        end
        PH_MSTACK: begin
          if (scl_rise) begin
            full_q <= 1'b1;
            mack_q <= ~sda_lvl;
          end else if (byte_end) begin
            full_q <= 1'b0;
            if (mack_q) begin
              tx_q   <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr_q  <= ptr_q + 1'b1;
              ph_q   <= PH_SEND;
            end else begin
              ph_q <= PH_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: own drive moves only while SCL is low (start/stop cleanup excepted)
  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_ev || stop_ev)) |-> !$past(scl_lvl))
    else $error("SDA drive changed while SCL high");

  // R9: inside the write window the link stays idle and silent
  assert_busy_deaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph_q == PH_IDLE && !sda_oe))
    else $error("link active during write window");

  // R1: the acknowledge slot always pulls SDA low
  assert_ack_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SLVACK) |-> sda_oe)
    else $error("acknowledge slot without drive");

  // R7: after a missing master acknowledge the line is released
  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HOLD || ph_q == PH_IDLE) |-> !sda_oe)
    else $error("SDA driven while waiting for stop");

endmodule

// File: rtl/pd_spd_slave.sv
module pd_spd_slave
  import pd_spd_pkg::*;
#(
  parameter logic [3:0]  DEV_FAMILY   = 4'b1010,
  parameter int          MEM_BYTES    = 256,
  parameter int unsigned WR_BUSY_CLKS = 1000000,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_sel,
  output logic       sda_oe
);
  localparam int PTR_W = $clog2(MEM_BYTES);

  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic              busy, launch, wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  pd_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  pd_write_timer #(.BUSY_CLKS(WR_BUSY_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy)
  );

  pd_spd_store #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  pd_link_fsm #(.DEV_FAMILY(DEV_FAMILY), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_sel), .busy(busy), .rd_data(rd_data), .launch(launch),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .sda_oe(sda_oe)
  );

endmodule

// File: tb/tb_pd_spd_slave.sv
`timescale 1ns/1ps
module tb_pd_spd_slave;
  localparam int BUSY = 300;
  localparam int Q = 4;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] WADDR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] RADDR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = STRAP;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_vec = 0, n_bad = 0, r2_viol = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;

  pd_spd_slave #(.WR_BUSY_CLKS(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_sel(strap), .sda_oe(sda_oe)
  );

  // R2 monitor: drive may move only while SCL is held low
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(posedge clk) begin
    if (rst_n && scl && scl_prev && (sda_oe !== oe_prev)) r2_viol++;
    oe_prev  = sda_oe;
    scl_prev = scl;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    hw(Q); sda_m = b; hw(Q); scl = 1'b1; hw(H); scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    hw(Q); sda_m = 1'b1; hw(Q); scl = 1'b1; hw(Q); b = sda_bus; hw(Q); scl = 1'b0;
  endtask

  task automatic bus_start;
    hw(Q); sda_m = 1'b1; hw(Q); scl = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl = 1'b0;
  endtask

  task automatic bus_stop;
    hw(Q); sda_m = 1'b0; hw(Q); scl = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(r);
    acked = !r;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin recv_bit(r); b[i] = r; end
    send_bit(!give_ack);
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    bit a;
    logic [7:0] idx;
    bus_start;
    wr_byte(WADDR, a); chk(a, "R1", "write address ack", a, 1);
    wr_byte(p, a);     chk(a, "R3", "pointer ack", a, 1);
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], a); chk(a, "R3", "data ack", a, 1);
      idx = p + 8'(k);
      if (idx >= 8'd128) model[idx] = wbuf[k];
    end
    bus_stop;
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input string tag);
    bit a;
    logic [7:0] b, idx;
    bus_start;
    wr_byte(WADDR, a); chk(a, "R1", "address ack", a, 1);
    wr_byte(p, a);     chk(a, "R3", "pointer ack", a, 1);
    bus_start;
    wr_byte(RADDR, a); chk(a, "R6", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, b);
      idx = p + 8'(k);
      chk(b === model[idx], (k >= 256) ? "R5" : tag, "read data", b, model[idx]);
    end
    bus_stop;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    bit a;
    logic r;
    logic [7:0] b, sum;
    bit all_high;

    // expected contents (R10)
    model[0] = 8'h80; model[1] = 8'h08; model[2] = 8'h04; model[3] = 8'h0B; model[4] = 8'h08;
    for (int j = 5; j < 63; j++) model[j] = 8'(j) ^ 8'h5A;
    sum = 8'h00;
    for (int j = 0; j < 63; j++) sum = sum + model[j];
    model[63] = sum;
    for (int j = 64; j < 128; j++) model[j] = 8'hFF;
    for (int j = 128; j < 256; j++) model[j] = 8'h00;
    void'($urandom(32'h5EED_0C0D));

    hw(5); rst_n = 1'b1; hw(4);
    // R11: released after reset
    all_high = 1'b1;
    for (int i = 0; i < 20; i++) begin hw(1); if (sda_bus !== 1'b1) all_high = 1'b0; end
    chk(all_high, "R11", "sda after reset", all_high, 1);

    // R8: traffic with no start draws nothing
    hw(Q); scl = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(WADDR[i]);
    recv_bit(r);
    chk(r === 1'b1, "R8", "ack without start", r, 1);

    // R1: other straps in the family are not acknowledged
    bus_start;
    wr_byte(8'hA4, a); chk(!a, "R1", "foreign address ack", a, 0);
    wr_byte(8'h00, a); chk(!a, "R1", "silent after mismatch", a, 0);
    bus_stop;

    // R10, R5: whole space plus wrap from a random read at 0
    do_read(8'h00, 257, "R10");

    // R3, R4, R5: write across the wrap, lower bytes must stay
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(8'hFE, 4);
    // R9: address refused inside the window
    bus_start;
    wr_byte(WADDR, a); chk(!a, "R9", "ack during write window", a, 0);
    bus_stop;
    hw(BUSY + 40);
    bus_start;
    wr_byte(WADDR, a); chk(a, "R9", "ack after write window", a, 1);
    bus_stop;

    do_read(8'hFE, 3, "R4");

    // R5, R7: current-address read then nack hold
    bus_start;
    wr_byte(RADDR, a); chk(a, "R1", "read address ack", a, 1);
    rd_byte(1'b0, b);  chk(b === model[1], "R5", "current address data", b, model[1]);
    all_high = 1'b1;
    for (int i = 0; i < 9; i++) begin recv_bit(r); if (r !== 1'b1) all_high = 1'b0; end
    chk(all_high, "R7", "sda released after nack", all_high, 1);
    bus_stop;

    // R9, R3: pointer-only write opens no window and sets the pointer
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
    do_write(8'h90, 2);
    hw(BUSY + 40);
    bus_start;
    wr_byte(WADDR, a); chk(a, "R1", "address ack", a, 1);
    wr_byte(8'h91, a); chk(a, "R3", "pointer ack", a, 1);
    bus_stop;
    bus_start;
    wr_byte(RADDR, a); chk(a, "R9", "no window after pointer-only write", a, 1);
    rd_byte(1'b0, b);  chk(b === model[8'h91], "R3", "pointer set by write", b, model[8'h91]);
    bus_stop;

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic [7:0] p, q;
      int n, m;
      p = 8'($urandom_range(0, 255));
      n = $urandom_range(1, 5);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(p, n);
      hw(BUSY + 40);
      q = (it % 2 == 0) ? p : 8'($urandom_range(0, 255));
      m = $urandom_range(1, 4);
      do_read(q, m, "R4");
    end

    chk(r2_viol == 0, "R2", "drive changes while SCL high", r2_viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule